// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM. The address, write data and every control input are registered on the rising clock edge, and read data passes through one further output register before it reaches the outputs. A processor strobe or a cache-controller strobe opens an access at an external address. After that, each cycle with the advance input low moves an internal two-bit burst counter to the next beat. A burst has four beats, and the counter steps through them in either linear or interleaved order.

A write can cover the whole 32-bit word under the global write control, or only chosen bytes under the byte-write enable and its four byte selects. A three-input chip select lets several devices share a bus. A deselect cuts the read pipeline off after a single cycle. Output enable and the sleep input act at once, without waiting for a clock edge. The data bus is split into a data-in port, a data-out port and an output-drive flag. The address width is a parameter: a value of 16 gives 65,536 words of 32 bits, and the default is smaller to keep elaboration light.

Top module: `sync_burst_sram`

## Requirements
- R1: The array holds 2^AW words of DW bits (AW=16 gives 65,536 x 32). A word written at an address is returned unchanged by a later read of that address.
- R2: An access is registered on clock edge k. For a read, `dout` holds the word and the read-valid state is set after edge k+1. A write or idle cycle leaves read-valid clear after edge k+1.
- R3: While a burst is active, each edge with `adv_n` low and no new start moves the counter to the next of four beats, wrapping after the fourth. Let b be the two low start-address bits and i the beat number 0..3. With `lin_burst`=1 the beat's low bits are (b+i) mod 4. With `lin_burst`=0 they are b XOR i. The upper bits keep the start address.
- R4: An edge with `adv_n` high and no new start, during an active burst, repeats the access at the current beat address.
- R5: With `gw_n` low, a write stores all four bytes of `din`, whatever the values of `bwe_n` and `bw_n`.
- R6: With `gw_n` high and `bwe_n` low, only byte i (bits 8i+7..8i) for which `bw_n[i]`=0 is written, and the other bytes keep their value. With both high, the cycle is a read.
- R7: A processor start (`adsp_n`=0 while `ce_n`=0) is always a read. A processor strobe seen while `ce_n`=1 is ignored. A controller start (`adsc_n`=0) looks at the write controls in the same edge.
- R8: The chip is selected when `ce_n`=0, `cs_hi`=1 and `cs_n`=0. A start edge seen while the chip is not selected ends the burst. `dout_en` is then low after the next edge, and later cycles without a start do nothing.
- R9: `dout_en` = !`oe_n` & !`zz` & read-valid. It follows `oe_n` and `zz` without a clock edge.
- R10: At an edge with `zz` high, nothing is written, including a write registered one edge earlier. No access is registered, the burst ends, and the stored words are kept.
- R11: After reset, `dout_en` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset of control state, active low |
| addr | input | AW | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-byte write selects, active low |
| lin_burst | input | 1 | 1 = linear beat order, 0 = interleaved |
| zz | input | 1 | Sleep, active high, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| din | input | DW | Write data |
| dout | output | DW | Read data from the output register |
| dout_en | output | 1 | Output drive flag |

## Verification
The bench starts bursts at every low-bit offset in both orders. A wrong counter here would show up as beats arriving in the wrong order, or failing to wrap back to the start word. It splits a word with byte writes and sends a global write with the byte selects set against it, which exposes a mask that does not merge bytes or that lets the byte selects win over the global write. It also deselects in the middle of a burst, raises sleep between a write's registration and its array update, and toggles output enable and sleep between clock edges. A design with a stale pipeline, a write that survives sleep, or a clocked output enable would drive data one cycle too long, corrupt a word, or miss the mid-cycle change. A random phase compares every cycle against a behavioural model.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

    // beat offset inside a burst block: linear adds, interleaved flips bits
    function automatic logic [1:0] beat_off(input logic [1:0] start,
                                            input logic [1:0] idx,
                                            input logic       linear);
        return linear ? (start + idx) : (start ^ idx);
    endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] start_off,
    input  logic          lin_in,
    output logic [CW-1:0] nxt_off
);
    typedef struct packed {
        logic [CW-1:0] off;
        logic [CW-1:0] cnt;
        logic          lin;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (load) begin
            seq_d.off = start_off;
            seq_d.cnt = '0;
            seq_d.lin = lin_in;
        end else if (step) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
        if (seq_d.lin) nxt_off = seq_d.off + seq_d.cnt;
        else           nxt_off = seq_d.off ^ seq_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // each advance moves the counter by exactly one beat, wrapping
    p_step_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (seq_q.cnt == CW'($past(seq_q.cnt) + 1'b1)));

    // a load restarts at beat zero with the given offset
    p_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (seq_q.cnt == '0 && seq_q.off == $past(start_off)));

endmodule

// File: rtl/sram_wr_mask.sv
module sram_wr_mask #(
    parameter int NB = 4
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic [NB-1:0] mask
);
    always_comb begin
        if (!gw_n)       mask = '1;
        else if (!bwe_n) mask = ~bw_n;
        else             mask = '0;
    end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int AW = 10,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic          clk,
    input  logic [NB-1:0] wmask,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (wmask[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int BURST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic                adsp_n,
    input  logic                adsc_n,
    input  logic                adv_n,
    input  logic                ce_n,
    input  logic                cs_hi,
    input  logic                cs_n,
    input  logic                gw_n,
    input  logic                bwe_n,
    input  logic [DW/8-1:0]     bw_n,
    input  logic                lin_burst,
    input  logic                zz,
    input  logic                oe_n,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       dout,
    output logic                dout_en
);
    import sram_pkg::*;

    localparam int NB = DW / 8;
    localparam int CW = $clog2(BURST);
    localparam int HW = AW - CW;

    typedef struct packed {
        logic          act;
        logic [HW-1:0] base_hi;
        cmd_e          cmd;
        logic [AW-1:0] eaddr;
        logic [DW-1:0] wdat;
        logic [NB-1:0] wmask;
        logic          rvld;
        logic [DW-1:0] dout;
    } st_t;

    st_t st_d, st_q;

    logic          sel, start_p, start_c, start, load, step;
    logic [NB-1:0] req_mask, arr_mask;
    logic [CW-1:0] off_nx;
    logic [DW-1:0] arr_rd;

    assign sel     = !ce_n && cs_hi && !cs_n;
    assign start_p = !adsp_n && !ce_n;
    assign start_c = !adsc_n;
    assign start   = start_p || start_c;
    assign load    = !zz && start && sel;
    assign step    = !zz && !start && st_q.act && !adv_n;

    sram_wr_mask #(.NB(NB)) u_mask (
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .mask  (req_mask)
    );

    sram_burst_seq #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .start_off (addr[CW-1:0]),
        .lin_in    (lin_burst),
        .nxt_off   (off_nx)
    );

    assign arr_mask = (!zz && st_q.cmd == CMD_WR) ? st_q.wmask : '0;

    sram_store #(.AW(AW), .DW(DW), .NB(NB)) u_store (
        .clk   (clk),
        .wmask (arr_mask),
        .addr  (st_q.eaddr),
        .wdata (st_q.wdat),
        .rdata (arr_rd)
    );

    always_comb begin
        st_d = st_q;
        // output stage: completes the access registered on the previous edge
        st_d.rvld = 1'b0;
        if (!zz && st_q.cmd == CMD_RD) begin
            st_d.rvld = 1'b1;
            st_d.dout = arr_rd;
        end
        // access stage
        st_d.cmd   = CMD_IDLE;
        st_d.wdat  = din;
        st_d.wmask = req_mask;
        if (zz) begin
            st_d.act = 1'b0;
        end else if (start) begin
            if (sel) begin
                st_d.act     = 1'b1;
                st_d.base_hi = addr[AW-1:CW];
                st_d.eaddr   = {addr[AW-1:CW], off_nx};
                if (start_p)        st_d.cmd = CMD_RD;
                else if (|req_mask) st_d.cmd = CMD_WR;
                else                st_d.cmd = CMD_RD;
            end else begin
                st_d.act = 1'b0;
            end
        end else if (st_q.act) begin
            st_d.eaddr = {st_q.base_hi, off_nx};
            st_d.cmd   = (|req_mask) ? CMD_WR : CMD_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_en = !oe_n && !zz && st_q.rvld;

    // a registered read shows up in the output register one edge later
    p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && st_q.cmd == CMD_RD) |=> st_q.rvld);

    // holding advance high keeps the beat address
    p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && st_q.act && adsc_n && (adsp_n || ce_n) && adv_n)
        |=> (st_q.eaddr == $past(st_q.eaddr)));

    // a processor-strobe start is a read
    p_adsp_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && !adsp_n && !ce_n && cs_hi && !cs_n) |=> (st_q.cmd == CMD_RD));

    // deselect drains the read pipeline within one further edge
    p_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && start && !sel) |-> ##2 !st_q.rvld);

    // sleep ends the burst
    p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> !st_q.act);

endmodule

// File: tb/sync_burst_sram_tb_top.sv
module sync_burst_sram_tb_top;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          adsp_n, adsc_n, adv_n, ce_n, cs_hi, cs_n;
    logic          gw_n, bwe_n, lin_burst, zz, oe_n;
    logic [NB-1:0] bw_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    string tag = "R11";

    // behavioural reference state
    logic [DW-1:0] mem [int];
    bit            m_act, m_lin, m_vld;
    int            m_base, m_cnt;
    int            p_cmd;       // 0 none, 1 read, 2 write
    int            p_addr;
    logic [DW-1:0] p_data, m_dout;
    logic [NB-1:0] p_mask;

    sync_burst_sram #(.AW(AW), .DW(DW), .BURST(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .cs_hi(cs_hi), .cs_n(cs_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .lin_burst(lin_burst), .zz(zz), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA5A5_0000 ^ (32'(a) * 32'h0001_0003);
    endfunction

    function automatic int beat_addr(input int base, input bit lin, input int i);
        int lo;
        lo = lin ? ((base + i) % 4) : ((base % 4) ^ i);
        return (base & ~3) | lo;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit sel, sp, st;
        logic [NB-1:0] mk;
        sel = !ce_n && cs_hi && !cs_n;
        sp  = !adsp_n && !ce_n;
        st  = sp || !adsc_n;
        mk  = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        if (zz) begin
            m_vld = 0; p_cmd = 0; m_act = 0;
            return;
        end
        m_vld = 0;
        if (p_cmd == 2) begin
            logic [DW-1:0] w;
            w = mem.exists(p_addr) ? mem[p_addr] : 'x;
            for (int b = 0; b < NB; b++) if (p_mask[b]) w[b*8 +: 8] = p_data[b*8 +: 8];
            mem[p_addr] = w;
        end else if (p_cmd == 1) begin
            m_vld  = 1;
            m_dout = mem.exists(p_addr) ? mem[p_addr] : 'x;
        end
        p_cmd = 0;
        if (st) begin
            if (sel) begin
                m_act = 1; m_base = int'(addr); m_cnt = 0; m_lin = lin_burst;
                p_addr = int'(addr);
                p_cmd  = sp ? 1 : ((mk != 0) ? 2 : 1);
            end else begin
                m_act = 0;
            end
        end else if (m_act) begin
            if (!adv_n) m_cnt = (m_cnt + 1) % 4;
            p_addr = beat_addr(m_base, m_lin, m_cnt);
            p_cmd  = (mk != 0) ? 2 : 1;
        end
        p_data = din;
        p_mask = mk;
    endtask

    // one clock: model follows the edge, outputs compared mid-low-phase
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, 32'(dout_en), 32'(!oe_n && !zz && m_vld), "dout_en");
        if (m_vld && !$isunknown(m_dout)) chk(tag, dout, m_dout, "dout");
    endtask

    task automatic quiet();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        ce_n = 0; cs_hi = 1; cs_n = 0; zz = 0; oe_n = 0;
    endtask

    task automatic desel();
        quiet(); adsc_n = 0; ce_n = 1;
        cyc();
    endtask

    task automatic wr_word(input int a, input logic [DW-1:0] d);
        quiet(); adsc_n = 0; addr = AW'(a); gw_n = 0; din = d;
        cyc();
        desel();
    endtask

    task automatic burst_write(input int base, input bit lin);
        lin_burst = lin;
        for (int k = 0; k < 4; k++) begin
            quiet(); gw_n = 0;
            if (k == 0) begin adsc_n = 0; addr = AW'(base); end
            else adv_n = 0;
            din = pat(beat_addr(base, lin, k));
            cyc();
        end
        desel();
    endtask

    task automatic burst_read(input int base, input bit lin, input string req);
        lin_burst = lin;
        tag = req;
        for (int k = 0; k < 5; k++) begin
            quiet();
            if (k == 0) begin adsp_n = 0; addr = AW'(base); end
            else if (k < 4) adv_n = 0;
            else begin adsc_n = 0; ce_n = 1; end
            cyc();
            if (k >= 1) begin
                chk(req, 32'(dout_en), 32'd1, "beat valid");
                chk(req, dout, pat(beat_addr(base, lin, k - 1)), "beat data");
            end
        end
        quiet(); adsc_n = 0; ce_n = 1;
        cyc();
        chk("R8", 32'(dout_en), 32'd0, "drive after deselect");
    endtask

    task automatic rd_word(input int a, input logic [DW-1:0] exp, input string req);
        tag = req;
        quiet(); adsc_n = 0; addr = AW'(a);
        cyc();
        desel();
        chk(req, dout, exp, "read word");
        chk(req, 32'(dout_en), 32'd1, "read valid");
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0; quiet(); addr = '0; din = '0; lin_burst = 1;
        m_act = 0; m_vld = 0; p_cmd = 0; m_lin = 1; m_base = 0; m_cnt = 0;
        p_addr = 0; p_data = '0; p_mask = '0; m_dout = '0;
        repeat (3) @(negedge clk);
        chk("R11", 32'(dout_en), 32'd0, "reset drive");
        rst_n = 1;
        tag = "R11";
        desel();

        // R1: single word write and read back
        tag = "R1";
        wr_word(5, 32'hDEAD_BEEF);
        rd_word(5, 32'hDEAD_BEEF, "R1");
        wr_word(1023, 32'h0123_4567);
        rd_word(1023, 32'h0123_4567, "R1");

        // R2: latency, output appears exactly one edge after registration
        tag = "R2";
        quiet(); adsc_n = 0; addr = AW'(5);
        cyc();
        chk("R2", 32'(dout_en), 32'd0, "no data at registration edge");
        quiet(); adsc_n = 0; ce_n = 1;
        cyc();
        chk("R2", 32'(dout_en), 32'd1, "data one edge later");
        chk("R2", dout, 32'hDEAD_BEEF, "latency data");
        desel();

        // R3: bursts from every offset in both orders
        tag = "R3";
        for (int off = 0; off < 4; off++) begin
            burst_write(16'h40 + off * 8 + off, 1'b1);
            burst_read(16'h40 + off * 8 + off, 1'b1, "R3");
            burst_read(16'h40 + off * 8 + off, 1'b0, "R3");
        end
        burst_write(16'h83, 1'b0);
        burst_read(16'h81, 1'b0, "R3");

        // R4: suspend repeats the beat address
        tag = "R4";
        burst_write(16'h90, 1'b1);
        quiet(); adsp_n = 0; addr = AW'(16'h91); lin_burst = 1;
        cyc();
        quiet(); adv_n = 1;
        cyc();
        chk("R4", dout, pat(16'h91), "beat 0");
        quiet(); adv_n = 1;
        cyc();
        chk("R4", dout, pat(16'h91), "suspended beat repeats");
        quiet(); adv_n = 0;
        cyc();
        chk("R4", dout, pat(16'h91), "last suspended beat");
        desel();
        chk("R4", dout, pat(16'h92), "advance after suspend");
        desel();

        // R5: global write overrides byte controls
        tag = "R5";
        wr_word(200, 32'h1111_1111);
        quiet(); adsc_n = 0; addr = AW'(200); gw_n = 0; bwe_n = 0; bw_n = 4'b1110;
        din = 32'hCAFE_F00D;
        cyc();
        desel();
        rd_word(200, 32'hCAFE_F00D, "R5");

        // R6: byte writes merge, disabled bytes keep
        tag = "R6";
        wr_word(300, 32'h1122_3344);
        quiet(); adsc_n = 0; addr = AW'(300); bwe_n = 0; bw_n = 4'b1010;
        din = 32'hAABB_CCDD;
        cyc();
        desel();
        rd_word(300, 32'h11BB_33DD, "R6");
        quiet(); adsc_n = 0; addr = AW'(300); bwe_n = 1; bw_n = 4'b0000;
        din = 32'h0;
        cyc();
        desel();
        rd_word(300, 32'h11BB_33DD, "R6");

        // R7: processor start reads even with write set; write follows in next cycle
        tag = "R7";
        quiet(); adsp_n = 0; addr = AW'(5); gw_n = 0; din = 32'h7777_7777;
        cyc();
        quiet(); adv_n = 1; gw_n = 0; din = 32'h3C3C_3C3C;
        cyc();
        chk("R7", dout, 32'hDEAD_BEEF, "processor start was a read");
        desel();
        rd_word(5, 32'h3C3C_3C3C, "R7");
        // processor strobe with chip enable high is ignored
        quiet(); adsp_n = 0; ce_n = 1; addr = AW'(5);
        cyc();
        quiet(); ce_n = 1;
        cyc();
        chk("R7", 32'(dout_en), 32'd0, "ignored strobe no read");
        desel();

        // R8: deselect by a chip select mid-burst
        tag = "R8";
        quiet(); adsp_n = 0; addr = AW'(16'h40); lin_burst = 1;
        cyc();
        quiet(); adv_n = 0;
        cyc();
        quiet(); adsc_n = 0; cs_hi = 0; addr = AW'(16'h40);
        cyc();
        chk("R8", 32'(dout_en), 32'd1, "beat before deselect");
        quiet(); adv_n = 0;
        cyc();
        chk("R8", 32'(dout_en), 32'd0, "drained after deselect");
        quiet(); adv_n = 0; gw_n = 0; din = 32'h0;
        cyc();
        chk("R8", 32'(dout_en), 32'd0, "no access while ended");
        desel();
        burst_read(16'h40, 1'b1, "R8");

        // R9: asynchronous output enable and sleep gating
        tag = "R9";
        quiet(); adsc_n = 0; addr = AW'(5);
        cyc();
        quiet(); adv_n = 1;
        cyc();
        oe_n = 1; #2;
        chk("R9", 32'(dout_en), 32'd0, "oe_n high drops drive");
        oe_n = 0; #2;
        chk("R9", 32'(dout_en), 32'd1, "oe_n low restores drive");
        zz = 1; #2;
        chk("R9", 32'(dout_en), 32'd0, "zz high drops drive");
        zz = 0; #2;
        chk("R9", 32'(dout_en), 32'd1, "zz low restores drive");
        desel();

        // R10: writes during sleep and pending writes are dropped
        tag = "R10";
        wr_word(400, 32'h5555_AAAA);
        quiet(); zz = 1; adsc_n = 0; addr = AW'(400); gw_n = 0; din = 32'h0;
        cyc();
        quiet(); adsc_n = 0; addr = AW'(400); gw_n = 0; din = 32'h1234_0000;
        cyc();
        quiet(); zz = 1; adsc_n = 0; ce_n = 1;
        cyc();
        desel();
        rd_word(400, 32'h5555_AAAA, "R10");
        quiet(); adsp_n = 0; addr = AW'(16'h40);
        cyc();
        quiet(); zz = 1; adv_n = 0;
        cyc();
        quiet(); adv_n = 0;
        cyc();
        quiet(); adv_n = 0;
        cyc();
        chk("R10", 32'(dout_en), 32'd0, "burst ended by sleep");
        desel();

        // random phase against the behavioural model
        tag = "R2";
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 99);
            quiet();
            addr = AW'($urandom_range(0, 15) + 16'h100);
            din = $urandom();
            lin_burst = $urandom_range(0, 1);
            adsp_n = (r < 15) ? 1'b0 : 1'b1;
            adsc_n = (r >= 15 && r < 30) ? 1'b0 : 1'b1;
            adv_n  = $urandom_range(0, 3) == 0;
            ce_n   = $urandom_range(0, 9) == 0;
            cs_hi  = $urandom_range(0, 9) != 0;
            gw_n   = $urandom_range(0, 3) != 0;
            bwe_n  = $urandom_range(0, 2) != 0;
            bw_n   = 4'($urandom_range(0, 15));
            oe_n   = $urandom_range(0, 7) == 0;
            zz     = $urandom_range(0, 30) == 0;
            cyc();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule